// File: doc/BRIEF.md
# Inbound MSI Vector Capture Bank

This block sits between the inbound write path of a PCIe root port and the CPU's interrupt controller. Each inbound message-signalled interrupt arrives as one write on a single-cycle port. The block checks the write address against a programmable target window. When the address hits, the write data names one of 256 vectors, and the block latches the pending bit for that vector. Writes that miss the window, and writes whose data names no vector, leave no trace.

Software programs the window base and the window length, given in 4 KiB pages. It then sets per-vector enable bits and unmasks the summary interrupt. The interrupt handler reads eight 32-bit pending words and acknowledges vectors by writing ones back to them. A single registered interrupt line is raised while any enabled vector is pending and the mask bit is set.

The register port is a plain 32-bit write strobe with a combinational read of the addressed word. The pending and enable arrays are built from one repeated word slice per 32 vectors.

Top module: `msi_vec_bank`

## Requirements
- R1: After reset every register reads zero: base, size, mask, all pending words and all enable words. The interrupt output is low.
- R2: The window base is written and read at offset 0x68, and offset 0x64 is an alias of the same register. The window length is at offset 0x60, counted in 4 KiB pages. The interrupt mask is bit 0 at offset 0xb4. Unmapped offsets read zero, and writes to them have no effect.
- R3: An inbound write hits only when base <= address < base + pages*4096, computed without wrap-around. With pages equal to 0 nothing hits. A write that misses changes no pending bit.
- R4: On a hit, write data below 256 selects pending word data[7:5], bit data[4:0]. Data of 256 or more is ignored. Exactly one bit can become pending per write.
- R5: A vector whose enable bit is 0 in the cycle of the write does not latch a pending bit.
- R6: Pending word i reads at offset 0x6c + 4*i, and enable word i at offset 0x8c + 4*i, for i = 0..7. An enable word holds whatever software last wrote to it.
- R7: Writing a pending word clears every bit written as 1 and leaves every bit written as 0 unchanged.
- R8: If an inbound write sets a bit in the same cycle that software clears it, the bit ends up set.
- R9: The interrupt output equals, one cycle later, the mask bit ANDed with the OR over all vectors of pending AND enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously to clk |
| msi_wr_valid | input | 1 | Inbound interrupt write present this cycle |
| msi_wr_addr | input | 32 | Inbound write address (32-bit only) |
| msi_wr_data | input | 32 | Inbound write data, the vector index |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Contents of the register at reg_addr |
| irq_o | output | 1 | Registered summary interrupt |

## Verification
The risky case is an inbound write that sets a vector in the same cycle that software clears that vector's word. A second such case is an inbound write that lands in the same cycle that software rewrites the enable word gating it. The bench provokes both on purpose in directed steps, then again at random across many cycles. Each time, a behavioural model applies clears before sets and samples enables from before the edge. The pending words and the interrupt line are compared against that model on every clock.

// File: rtl/msi_bank_pkg.sv
`timescale 1ns/1ps
package msi_bank_pkg;
  localparam int REG_AW = 8;

  // register byte offsets
  localparam logic [REG_AW-1:0] OFF_SIZE     = 8'h60;
  localparam logic [REG_AW-1:0] OFF_BASE_ALT = 8'h64;
  localparam logic [REG_AW-1:0] OFF_BASE     = 8'h68;
  localparam logic [REG_AW-1:0] OFF_PEND0    = 8'h6c;
  localparam logic [REG_AW-1:0] OFF_EN0      = 8'h8c;
  localparam logic [REG_AW-1:0] OFF_MASK     = 8'hb4;

  function automatic logic [REG_AW-1:0] word_off(input logic [REG_AW-1:0] first, input int idx);
    return first + REG_AW'(idx * 4);
  endfunction
endpackage

// File: rtl/msi_window_match.sv
`timescale 1ns/1ps
module msi_window_match #(
  parameter int ADDR_W     = 32,
  parameter int SZ_W       = 8,
  parameter int PAGE_SHIFT = 12
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] base,
  input  logic [SZ_W-1:0]   pages,
  output logic              hit
);
  localparam int EXT_W = ADDR_W + SZ_W + PAGE_SHIFT + 1;

  logic [EXT_W-1:0] addr_x;
  logic [EXT_W-1:0] base_x;
  logic [EXT_W-1:0] span_x;
  logic [EXT_W-1:0] limit_x;

  // widened compare: the upper bound never wraps
  always_comb begin
    addr_x  = EXT_W'(addr);
    base_x  = EXT_W'(base);
    span_x  = EXT_W'(pages) << PAGE_SHIFT;
    limit_x = base_x + span_x;
    hit     = (addr_x >= base_x) && (addr_x < limit_x);
  end
endmodule

// File: rtl/msi_vec_decode.sv
`timescale 1ns/1ps
module msi_vec_decode #(
  parameter int NUM_WORDS = 8,
  parameter int WORD_W    = 32,
  parameter int DATA_W    = 32
) (
  input  logic                          fire,
  input  logic [DATA_W-1:0]             data,
  input  logic [NUM_WORDS*WORD_W-1:0]   en_flat,
  output logic [NUM_WORDS*WORD_W-1:0]   set_flat
);
  localparam int NUM_VEC = NUM_WORDS * WORD_W;
  localparam int IDX_W   = $clog2(NUM_VEC);

  logic             in_range;
  logic [IDX_W-1:0] idx;

  always_comb begin
    in_range = (data >> IDX_W) == '0;
    idx      = data[IDX_W-1:0];
  end

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
    assign set_flat[v] = fire && in_range && (idx == IDX_W'(v)) && en_flat[v];
  end
endmodule

// File: rtl/msi_status_word.sv
`timescale 1ns/1ps
module msi_status_word #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] set_bits,
  input  logic              clr_we,
  input  logic [WORD_W-1:0] clr_bits,
  input  logic              en_we,
  input  logic [WORD_W-1:0] en_bits,
  output logic [WORD_W-1:0] pend_q,
  output logic [WORD_W-1:0] en_q
);
  logic [WORD_W-1:0] pend_d;
  logic [WORD_W-1:0] clr_mask;
  logic              pend_ce;

  // clear first, then set: a same-cycle set survives
  always_comb begin
    clr_mask = clr_we ? clr_bits : '0;
    pend_d   = (pend_q & ~clr_mask) | set_bits;
    pend_ce  = clr_we | (|set_bits);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      en_q   <= '0;
    end else begin
      if (pend_ce) pend_q <= pend_d;
      if (en_we)   en_q   <= en_bits;
    end
  end
endmodule

// File: rtl/msi_vec_bank.sv
`timescale 1ns/1ps
module msi_vec_bank
  import msi_bank_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int NUM_WORDS  = 8,
  parameter int SZ_W       = 8,
  parameter int PAGE_SHIFT = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              msi_wr_valid,
  input  logic [ADDR_W-1:0] msi_wr_addr,
  input  logic [DATA_W-1:0] msi_wr_data,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_o
);
  localparam int WORD_W  = DATA_W;
  localparam int NUM_VEC = NUM_WORDS * WORD_W;

  logic [ADDR_W-1:0] base_q, base_d;
  logic [SZ_W-1:0]   size_q, size_d;
  logic              mask_q, mask_d;
  logic              base_we, size_we, mask_we;
  logic              win_hit;
  logic              irq_d;

  logic [NUM_VEC-1:0] set_flat;
  logic [NUM_VEC-1:0] pend_flat;
  logic [NUM_VEC-1:0] en_flat;
  logic [WORD_W-1:0]  pend_w [NUM_WORDS];
  logic [WORD_W-1:0]  en_w   [NUM_WORDS];
  logic [NUM_WORDS-1:0] pend_we;
  logic [NUM_WORDS-1:0] en_we;

  // control register decode
  always_comb begin
    base_we = reg_wr && ((reg_addr == OFF_BASE) || (reg_addr == OFF_BASE_ALT));
    size_we = reg_wr && (reg_addr == OFF_SIZE);
    mask_we = reg_wr && (reg_addr == OFF_MASK);
    base_d  = reg_wdata[ADDR_W-1:0];
    size_d  = reg_wdata[SZ_W-1:0];
    mask_d  = reg_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      size_q <= '0;
      mask_q <= 1'b0;
    end else begin
      if (base_we) base_q <= base_d;
      if (size_we) size_q <= size_d;
      if (mask_we) mask_q <= mask_d;
    end
  end

  msi_window_match #(
    .ADDR_W    (ADDR_W),
    .SZ_W      (SZ_W),
    .PAGE_SHIFT(PAGE_SHIFT)
  ) u_win (
    .addr (msi_wr_addr),
    .base (base_q),
    .pages(size_q),
    .hit  (win_hit)
  );

  msi_vec_decode #(
    .NUM_WORDS(NUM_WORDS),
    .WORD_W   (WORD_W),
    .DATA_W   (DATA_W)
  ) u_dec (
    .fire    (msi_wr_valid && win_hit),
    .data    (msi_wr_data),
    .en_flat (en_flat),
    .set_flat(set_flat)
  );

  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
    assign pend_we[i] = reg_wr && (reg_addr == word_off(OFF_PEND0, i));
    assign en_we[i]   = reg_wr && (reg_addr == word_off(OFF_EN0, i));

    msi_status_word #(.WORD_W(WORD_W)) u_word (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_bits(set_flat[i*WORD_W +: WORD_W]),
      .clr_we  (pend_we[i]),
      .clr_bits(reg_wdata),
      .en_we   (en_we[i]),
      .en_bits (reg_wdata),
      .pend_q  (pend_w[i]),
      .en_q    (en_w[i])
    );

    assign pend_flat[i*WORD_W +: WORD_W] = pend_w[i];
    assign en_flat[i*WORD_W +: WORD_W]   = en_w[i];
  end

  // read mux
  always_comb begin
    reg_rdata = '0;
    if ((reg_addr == OFF_BASE) || (reg_addr == OFF_BASE_ALT)) reg_rdata = DATA_W'(base_q);
    if (reg_addr == OFF_SIZE) reg_rdata = DATA_W'(size_q);
    if (reg_addr == OFF_MASK) reg_rdata = DATA_W'(mask_q);
    for (int i = 0; i < NUM_WORDS; i++) begin
      if (reg_addr == word_off(OFF_PEND0, i)) reg_rdata = pend_w[i];
      if (reg_addr == word_off(OFF_EN0, i))   reg_rdata = en_w[i];
    end
  end

  // summary interrupt
  always_comb irq_d = mask_q && (|(pend_flat & en_flat));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= irq_d;
  end
endmodule

// File: rtl/msi_vec_bank_chk.sv
`timescale 1ns/1ps
module msi_vec_bank_chk #(
  parameter int DATA_W  = 32,
  parameter int NUM_VEC = 256
) (
  input logic               clk,
  input logic               rst_n,
  input logic               msi_wr_valid,
  input logic [DATA_W-1:0]  msi_wr_data,
  input logic               win_hit,
  input logic               reg_wr,
  input logic [NUM_VEC-1:0] pend_flat,
  input logic [NUM_VEC-1:0] en_flat,
  input logic               mask_q,
  input logic               irq_o
);
  localparam int IDX_W = $clog2(NUM_VEC);

  logic in_range;
  assign in_range = (msi_wr_data >> IDX_W) == '0;

  // R4/R8: a valid hit on an enabled vector is pending next cycle, even under a clear
  a_r4_hit_latches: assert property (@(posedge clk) disable iff (!rst_n)
    msi_wr_valid && win_hit && in_range && en_flat[msi_wr_data[IDX_W-1:0]]
    |=> pend_flat[$past(msi_wr_data[IDX_W-1:0])]);

  a_r8_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && msi_wr_valid && win_hit && in_range && en_flat[msi_wr_data[IDX_W-1:0]]
    |=> pend_flat[$past(msi_wr_data[IDX_W-1:0])]);

  // R3: nothing becomes pending without a window hit
  a_r3_no_rise_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
    !(msi_wr_valid && win_hit) |=> ((pend_flat & ~$past(pend_flat)) == '0));

  // R4: out-of-range data sets nothing; at most one bit rises per cycle
  a_r4_range_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    !in_range |=> ((pend_flat & ~$past(pend_flat)) == '0));

  a_r4_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($countones(pend_flat & ~$past(pend_flat)) <= 1));

  // R5: disabled vector does not latch
  a_r5_disabled_drop: assert property (@(posedge clk) disable iff (!rst_n)
    in_range && !en_flat[msi_wr_data[IDX_W-1:0]] |=> ((pend_flat & ~$past(pend_flat)) == '0));

  // R9: registered summary
  a_r9_summary: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_o == $past(mask_q && (|(pend_flat & en_flat)))));
endmodule

bind msi_vec_bank msi_vec_bank_chk #(
  .DATA_W (DATA_W),
  .NUM_VEC(NUM_VEC)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .msi_wr_valid(msi_wr_valid),
  .msi_wr_data (msi_wr_data),
  .win_hit     (win_hit),
  .reg_wr      (reg_wr),
  .pend_flat   (pend_flat),
  .en_flat     (en_flat),
  .mask_q      (mask_q),
  .irq_o       (irq_o)
);

// File: tb/msi_vec_bank_tb.sv
`timescale 1ns/1ps
module msi_vec_bank_tb;
  localparam time CLK_P = 20ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        msi_wr_valid;
  logic [31:0] msi_wr_addr;
  logic [31:0] msi_wr_data;
  logic        reg_wr;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        irq_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  msi_vec_bank u_dut (
    .clk(clk), .rst_n(rst_n),
    .msi_wr_valid(msi_wr_valid), .msi_wr_addr(msi_wr_addr), .msi_wr_data(msi_wr_data),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  // ---------------- behavioural reference model ----------------
  bit [255:0] m_pend;
  bit [255:0] m_en;
  bit [31:0]  m_base;
  bit [7:0]   m_size;
  bit         m_mask;
  bit         m_irq;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pend = '0; m_en = '0; m_base = 0; m_size = 0; m_mask = 0; m_irq = 0;
    end else begin
      bit nirq;
      bit [255:0] setv;
      longint lo, hi;
      nirq = m_mask && ((m_pend & m_en) != '0);
      setv = '0;
      lo = longint'(m_base);
      hi = lo + longint'(m_size) * 4096;
      if (msi_wr_valid && longint'(msi_wr_addr) >= lo && longint'(msi_wr_addr) < hi &&
          msi_wr_data < 256 && m_en[msi_wr_data[7:0]])
        setv[msi_wr_data[7:0]] = 1'b1;
      if (reg_wr) begin
        if (reg_addr == 8'h64 || reg_addr == 8'h68) m_base = reg_wdata;
        if (reg_addr == 8'h60) m_size = reg_wdata[7:0];
        if (reg_addr == 8'hb4) m_mask = reg_wdata[0];
        for (int i = 0; i < 8; i++) begin
          if (reg_addr == 8'(8'h6c + 4*i)) m_pend[i*32 +: 32] = m_pend[i*32 +: 32] & ~reg_wdata;
          if (reg_addr == 8'(8'h8c + 4*i)) m_en[i*32 +: 32] = reg_wdata;
        end
      end
      m_pend = m_pend | setv;
      m_irq = nirq;
    end
  end

  function automatic bit [31:0] mread(input bit [7:0] a);
    bit [31:0] v = 0;
    if (a == 8'h64 || a == 8'h68) v = m_base;
    if (a == 8'h60) v = {24'h0, m_size};
    if (a == 8'hb4) v = {31'h0, m_mask};
    for (int i = 0; i < 8; i++) begin
      if (a == 8'(8'h6c + 4*i)) v = m_pend[i*32 +: 32];
      if (a == 8'(8'h8c + 4*i)) v = m_en[i*32 +: 32];
    end
    return v;
  endfunction

  // ---------------- check helpers ----------------
  task automatic chk(input bit [31:0] got, input bit [31:0] exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  // one clock: check irq, drive, check readback of reg_addr when not writing
  task automatic cyc(input bit mv, input bit [31:0] ma, input bit [31:0] md,
                     input bit rw, input bit [7:0] ra, input bit [31:0] wd, input string tag);
    @(negedge clk);
    chk({31'h0, irq_o}, {31'h0, m_irq}, "R9 irq vs model");
    msi_wr_valid = mv; msi_wr_addr = ma; msi_wr_data = md;
    reg_wr = rw; reg_addr = ra; reg_wdata = wd;
    #1;
    if (!rw) chk(reg_rdata, mread(ra), tag);
  endtask

  task automatic wr(input bit [7:0] ra, input bit [31:0] wd, input string tag);
    cyc(0, 0, 0, 1, ra, wd, tag);
  endtask

  task automatic msi(input bit [31:0] ma, input bit [31:0] md, input string tag);
    cyc(1, ma, md, 0, 8'h6c, 0, tag);
  endtask

  task automatic rd(input bit [7:0] ra, input bit [31:0] exp, input string tag);
    cyc(0, 0, 0, 0, ra, 0, tag);
    chk(reg_rdata, exp, tag);
  endtask

  localparam bit [31:0] BASE = 32'h8000_0000;

  // ---------------- stimulus ----------------
  initial begin
    rst_n = 1'b0;
    msi_wr_valid = 0; msi_wr_addr = 0; msi_wr_data = 0;
    reg_wr = 0; reg_addr = 0; reg_wdata = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset values
    chk({31'h0, irq_o}, 32'h0, "R1 irq after reset");
    for (int a = 8'h60; a <= 8'hb4; a += 4) rd(8'(a), 32'h0, "R1 reset register");

    // R2: base, alias, size, mask, unmapped
    wr(8'h64, 32'h1234_5000, "R2");
    rd(8'h68, 32'h1234_5000, "R2 base alias read");
    wr(8'h68, BASE, "R2");
    rd(8'h64, BASE, "R2 alias sees base");
    wr(8'h60, 32'h0000_0001, "R2");
    rd(8'h60, 32'h1, "R2 size");
    wr(8'hb0, 32'hffff_ffff, "R2");
    rd(8'hb0, 32'h0, "R2 unmapped read zero");
    wr(8'hb4, 32'h1, "R2");
    rd(8'hb4, 32'h1, "R2 mask bit0");

    // R5: vector disabled -> no pending
    msi(BASE, 5, "R5");
    rd(8'h6c, 32'h0, "R5 disabled vector dropped");

    // R6: enables
    for (int i = 0; i < 8; i++) wr(8'(8'h8c + 4*i), 32'hffff_ffff, "R6");
    rd(8'h98, 32'hffff_ffff, "R6 enable word 3");

    // R4 + R9 latency
    msi(BASE + 32'h10, 0, "R4");
    cyc(0, 0, 0, 0, 8'h6c, 0, "R4");
    chk({31'h0, irq_o}, 32'h0, "R9 irq not yet");
    cyc(0, 0, 0, 0, 8'h6c, 0, "R4");
    chk({31'h0, irq_o}, 32'h1, "R9 irq one cycle after pending");
    msi(BASE + 32'hffc, 31, "R4");
    msi(BASE, 32, "R4");
    msi(BASE, 255, "R4");
    rd(8'h6c, 32'h8000_0001, "R4 word0 bits 0 and 31");
    rd(8'h70, 32'h0000_0001, "R4 word1 bit0");
    rd(8'h88, 32'h8000_0000, "R4 word7 bit31");

    // R3: misses and R4 range
    msi(BASE + 32'h1000, 40, "R3");
    msi(BASE - 32'h4, 41, "R3");
    msi(32'hffff_fff0, 42, "R3");
    msi(BASE, 256, "R4");
    msi(BASE, 32'h8000_0003, "R4");
    rd(8'h70, 32'h0000_0001, "R3 misses ignored");
    rd(8'h6c, 32'h8000_0001, "R4 out-of-range data ignored");

    // R7: write-one-to-clear
    wr(8'h6c, 32'h0000_0000, "R7");
    rd(8'h6c, 32'h8000_0001, "R7 zeros keep bits");
    wr(8'h6c, 32'h8000_0000, "R7");
    rd(8'h6c, 32'h0000_0001, "R7 one clears bit31");

    // R8: same-cycle set and clear
    cyc(1, BASE, 3, 1, 8'h6c, 32'hffff_ffff, "R8");
    rd(8'h6c, 32'h0000_0008, "R8 set wins over clear");

    // R5 timing: enable cleared in same cycle as MSI -> old enable used
    cyc(1, BASE, 70, 1, 8'h94, 32'h0, "R5");
    rd(8'h94, 32'h0, "R5 enable cleared");
    rd(8'h74, 32'h0000_0040, "R5 old enable gated the set");
    msi(BASE, 71, "R5");
    rd(8'h74, 32'h0000_0040, "R5 disabled vector dropped");

    // R9: mask off / pending but disabled
    wr(8'hb4, 32'h0, "R9");
    cyc(0, 0, 0, 0, 8'hb4, 0, "R9");
    cyc(0, 0, 0, 0, 8'hb4, 0, "R9");
    chk({31'h0, irq_o}, 32'h0, "R9 masked irq low");
    wr(8'hb4, 32'h1, "R9");
    for (int i = 0; i < 8; i++) wr(8'(8'h6c + 4*i), 32'hffff_ffff, "R7");
    msi(BASE, 70, "R5");
    cyc(0, 0, 0, 0, 8'h74, 0, "R9");
    cyc(0, 0, 0, 0, 8'h74, 0, "R9");
    chk({31'h0, irq_o}, 32'h0, "R9 disabled pending gives no irq");

    // R3: larger window, size zero
    for (int i = 0; i < 8; i++) wr(8'(8'h8c + 4*i), 32'hffff_ffff, "R6");
    wr(8'h60, 32'h2, "R3");
    msi(BASE + 32'h1ffc, 9, "R3");
    msi(BASE + 32'h2000, 10, "R3");
    rd(8'h6c, 32'h0000_0200, "R3 two-page window");
    wr(8'h60, 32'h0, "R3");
    msi(BASE, 11, "R3");
    rd(8'h6c, 32'h0000_0200, "R3 zero size hits nothing");
    wr(8'h60, 32'h3, "R3");

    // mixed random traffic, model compared every clock
    begin
      bit [31:0] s = 32'h1bad_c0de;
      for (int k = 0; k < 3000; k++) begin
        bit mv, rw;
        bit [31:0] ma, md, wd;
        bit [7:0] ra;
        s ^= s << 13; s ^= s >> 17; s ^= s << 5;
        mv = s[0];
        case (s[3:1])
          3'd0: ma = BASE - 32'h4;
          3'd1: ma = BASE + 32'h3000;
          3'd2: ma = BASE + 32'h2ffc;
          default: ma = BASE + {20'h0, s[27:16]};
        endcase
        md = (s[31:29] == 3'b111) ? 32'(256 + s[11:4]) : {24'h0, s[11:4]};
        rw = s[13] & s[14];
        ra = (s[20:16] < 5'd21) ? 8'(8'h60 + 4*s[20:16]) : 8'h6c;
        if (rw && (ra == 8'h60 || ra == 8'h64 || ra == 8'h68)) ra = 8'h6c;
        s ^= s << 13; s ^= s >> 17; s ^= s << 5;
        wd = (ra == 8'hb4) ? {31'h0, s[0]} : s;
        cyc(mv, ma, md, rw, ra, wd, "R6 random readback");
      end
    end
    for (int i = 0; i < 8; i++) rd(8'(8'h6c + 4*i), mread(8'(8'h6c + 4*i)), "R7 final pending");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule